// File: doc/BRIEF.md
# Selectable Serial Response Compactor

This block condenses the single-bit response stream of a circuit under test into a short signature. The signature is then checked against a known-good value. Four compaction methods run side by side on the same enabled bits: a count of ones, a count of level changes, a running odd/even parity, and a 16-bit serial signature register with XOR feedback. The `mode` input selects which result appears on `signature` and takes part in the comparison.

A test session starts with `clear`. The stream is then fed one bit per cycle while `enable` is high. A `finish` pulse compares the selected result with `golden` and latches the verdict on `pass`. A small controller has three states. EMPTY is the state after reset or clear, when no bit has been taken yet. ACTIVE is entered after the first enabled bit. HELD is entered after `finish`. The transitions are: EMPTY to ACTIVE on an enabled bit; EMPTY or ACTIVE to HELD on finish; any state to EMPTY on clear. In HELD all results and the verdict are frozen until the next clear.

Top module: `resp_compactor`

## Requirements
- R1: After reset or a clear, all four results read 0 on `signature` in every mode, and `pass` is 0. The clear takes effect at a single clock edge.
- R2: Mode 0 (ones count) adds one for each clock edge at which the bit is accepted with `resp_bit`=1. A bit is accepted when `enable`=1, `finish`=0, `clear`=0 and the state is not HELD.
- R3: Mode 1 (change count) adds one for each accepted bit that differs from the previously accepted bit. The first accepted bit after reset or clear is never counted.
- R4: Mode 2 (parity) shows the parity in bit 0 and zeros in the upper bits. Bit 0 is 1 when the number of accepted ones is odd and 0 when it is even.
- R5: Mode 3 (serial signature) updates on each accepted bit b as next = {s[14:0],0} XOR (16'h1021 when s[15] XOR b is 1). This is the polynomial x^16+x^12+x^5+1.
- R6: Both counters stop at 16'hFFFF and never wrap.
- R7: A `finish` pulse outside HELD sets `pass` to 1 exactly when the selected result, before that edge, equals `golden`. A bit presented in the same cycle as `finish` is not accepted.
- R8: In HELD, enabled bits change no result, and further `finish` pulses leave `pass` unchanged until the next clear.
- R9: `clear` takes priority over `enable` and `finish` in the same cycle.
- R10: With `enable`=0, no result changes, whatever `resp_bit` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of a session |
| enable | input | 1 | Accept `resp_bit` this cycle |
| resp_bit | input | 1 | Serial response bit |
| mode | input | 2 | 0 ones, 1 changes, 2 parity, 3 serial signature |
| golden | input | 16 | Expected result for the selected mode |
| finish | input | 1 | Compare and latch the verdict |
| signature | output | 16 | Selected result |
| pass | output | 1 | Latched verdict |

## Verification
The bench goes after the first bit after clear. A design that counts it as a change reads one too high in change mode. It checks a bit offered together with `finish` and bits offered after `finish`. A design that accepts either one drifts from the latched verdict. The counters are driven past 65535, where a wrapping counter would read a small number instead of 16'hFFFF. The bench also sends a clear together with enable and finish; a wrong priority there leaves stale state behind. The two first signature steps from zero are checked against fixed values, which shows up a wrong tap or shift direction.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [1:0] {
        MODE_ONES   = 2'd0,
        MODE_TRANS  = 2'd1,
        MODE_PARITY = 2'd2,
        MODE_SIG    = 2'd3
    } rc_mode_t;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HELD   = 2'd2
    } rc_state_t;
endpackage

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import rc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic finish,
    input  logic match,
    output logic acc_en,
    output logic first_bit,
    output logic pass
);
    rc_state_t st_q, st_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (finish)      st_d = ST_HELD;
                else if (enable) st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (finish) st_d = ST_HELD;
            end
            ST_HELD: st_d = ST_HELD;
            default: st_d = ST_EMPTY;
        endcase
        if (clear) st_d = ST_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        acc_en    = enable && !finish && !clear && (st_q != ST_HELD);
        first_bit = (st_q == ST_EMPTY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         pass <= 1'b0;
        else if (clear)                     pass <= 1'b0;
        else if (finish && st_q != ST_HELD) pass <= match;
    end

    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q == ST_EMPTY) && !pass);
    assert_held_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD) && !clear |=> $stable(pass));
    assert_no_accept_in_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD) |-> !acc_en);
endmodule

// File: rtl/rc_sat_counter.sv
module rc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (clear)                count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) && !clear |=> count == TOP);
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);
endmodule

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] sig
);
    logic fb;
    logic [W-1:0] nxt;

    always_comb begin
        fb  = sig[W-1] ^ din;
        nxt = {sig[W-2:0], 1'b0} ^ (fb ? TAPS : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sig <= '0;
        else if (clear) sig <= '0;
        else if (shift) sig <= nxt;
    end

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shift && !clear |=> $stable(sig));
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
    import rc_pkg::*;
#(
    parameter int              SIG_W = 16,
    parameter logic [SIG_W-1:0] TAPS  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             resp_bit,
    input  logic [1:0]       mode,
    input  logic [SIG_W-1:0] golden,
    input  logic             finish,
    output logic [SIG_W-1:0] signature,
    output logic             pass
);
    localparam int NCNT = 2;

    logic acc_en, first_bit, match;
    logic prev_q, par_q;
    logic [NCNT-1:0] cnt_inc;
    logic [SIG_W-1:0] cnt_val [NCNT];
    logic [SIG_W-1:0] lfsr_val;
    rc_mode_t sel;

    rc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
        .finish(finish), .match(match), .acc_en(acc_en),
        .first_bit(first_bit), .pass(pass)
    );

    assign cnt_inc[0] = acc_en && resp_bit;
    assign cnt_inc[1] = acc_en && !first_bit && (resp_bit != prev_q);

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        rc_sat_counter #(.W(SIG_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clear(clear),
            .inc(cnt_inc[g]), .count(cnt_val[g])
        );
    end

    rc_lfsr #(.W(SIG_W), .TAPS(TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .shift(acc_en),
        .din(resp_bit), .sig(lfsr_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            par_q  <= 1'b0;
        end else if (clear) begin
            prev_q <= 1'b0;
            par_q  <= 1'b0;
        end else if (acc_en) begin
            prev_q <= resp_bit;
            par_q  <= par_q ^ resp_bit;
        end
    end

    always_comb begin
        sel = rc_mode_t'(mode);
        unique case (sel)
            MODE_ONES:   signature = cnt_val[0];
            MODE_TRANS:  signature = cnt_val[1];
            MODE_PARITY: signature = {{(SIG_W-1){1'b0}}, par_q};
            MODE_SIG:    signature = lfsr_val;
            default:     signature = '0;
        endcase
        match = (signature == golden);
    end

    assert_parity_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && resp_bit |=> par_q != $past(par_q));
    assert_zero_keeps_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && !resp_bit |=> $stable(cnt_val[0]));
    assert_first_not_counted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && first_bit |=> $stable(cnt_val[1]));
    assert_finish_blocks_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finish && !clear |=> $stable(lfsr_val));
endmodule

// File: tb/resp_compactor_test.sv
module resp_compactor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, enable = 1'b0, resp_bit = 1'b0, finish = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [15:0] golden = 16'd0;
    logic [15:0] signature;
    logic pass;

    int checks = 0, fails = 0;
    bit ended = 0;

    // reference state
    int m_ones = 0, m_trans = 0, m_par = 0;
    logic [15:0] m_sig = 16'd0;
    bit m_prev = 0, m_have = 0, m_held = 0, m_pass = 0;

    always #10 clk = ~clk;

    resp_compactor uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
        .resp_bit(resp_bit), .mode(mode), .golden(golden), .finish(finish),
        .signature(signature), .pass(pass)
    );

    function automatic logic [15:0] model_val(input int md);
        case (md)
            0: return 16'(m_ones);
            1: return 16'(m_trans);
            2: return 16'(m_par);
            default: return m_sig;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic string mode_req(input int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit c, input bit en, input bit b, input bit fin);
        bit taken;
        clear = c; enable = en; resp_bit = b; finish = fin;
        @(posedge clk);
        taken = en && !fin && !c && !m_held;
        if (c) begin
            m_ones = 0; m_trans = 0; m_par = 0; m_sig = 0;
            m_prev = 0; m_have = 0; m_held = 0; m_pass = 0;
        end else begin
            if (fin && !m_held) begin
                m_pass = (model_val(int'(mode)) == golden);
                m_held = 1;
            end
            if (taken) begin
                bit fb;
                if (b && m_ones < 65535) m_ones++;
                if (m_have && (b != m_prev) && m_trans < 65535) m_trans++;
                m_par = m_par ^ int'(b);
                fb = m_sig[15] ^ b;
                m_sig = {m_sig[14:0], 1'b0};
                if (fb) m_sig = m_sig ^ 16'h1021;
                m_prev = b; m_have = 1;
            end
        end
        @(negedge clk);
        clear = 0; enable = 0; finish = 0;
        chk(mode_req(int'(mode)), signature, model_val(int'(mode)));
        chk("R7", {15'd0, pass}, {15'd0, m_pass});
    endtask

    task automatic read_all(input string req);
        logic [1:0] keep = mode;
        for (int md = 0; md < 4; md++) begin
            mode = 2'(md);
            #1;
            chk(req, signature, model_val(md));
        end
        mode = keep;
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int md = 0; md < 4; md++) begin
            mode = 2'(md); #1;
            chk("R1", signature, 16'd0);
        end
        chk("R1", {15'd0, pass}, 16'd0);

        // R5 fixed first two signature steps
        mode = 2'd3;
        step(0, 1, 1, 0);
        chk("R5", signature, 16'h1021);
        step(0, 1, 0, 0);
        chk("R5", signature, 16'h2042);
        step(1, 0, 0, 0);

        // R2 R3 R4 pattern 1,0,1,1
        mode = 2'd0;
        step(0, 1, 1, 0); step(0, 1, 0, 0); step(0, 1, 1, 0); step(0, 1, 1, 0);
        mode = 2'd0; #1; chk("R2", signature, 16'd3);
        mode = 2'd1; #1; chk("R3", signature, 16'd2);
        mode = 2'd2; #1; chk("R4", signature, 16'd1);
        read_all("R5");

        // R10 enable low with toggling bit
        for (int i = 0; i < 6; i++) step(0, 0, i[0], 0);
        read_all("R10");

        // R7 matching finish with a bit in the same cycle
        mode = 2'd3; golden = m_sig;
        step(0, 1, 1, 1);
        chk("R7", {15'd0, pass}, 16'd1);
        read_all("R7");

        // R8 held: bits and a mismatching finish change nothing
        golden = 16'hDEAD;
        for (int i = 0; i < 5; i++) step(0, 1, i[0], 0);
        step(0, 0, 0, 1);
        chk("R8", {15'd0, pass}, 16'd1);
        mode = 2'd0; #1; chk("R8", signature, 16'd3);
        read_all("R8");

        // R9 clear with enable and finish
        step(1, 1, 1, 1);
        read_all("R9");
        chk("R9", {15'd0, pass}, 16'd0);

        // R3 single first bit not counted
        step(0, 1, 1, 0);
        mode = 2'd1; #1; chk("R3", signature, 16'd0);
        mode = 2'd0; #1; chk("R2", signature, 16'd1);

        // R7 mismatch
        step(0, 1, 0, 0); step(0, 1, 1, 0);
        mode = 2'd1; golden = 16'd5;
        step(0, 0, 0, 1);
        chk("R7", {15'd0, pass}, 16'd0);

        // R4 parity pass
        step(1, 0, 0, 0);
        mode = 2'd2;
        step(0, 1, 1, 0); step(0, 1, 1, 0); step(0, 1, 1, 0);
        golden = 16'd1;
        step(0, 0, 0, 1);
        chk("R4", {15'd0, pass}, 16'd1);

        // R6 ones saturation
        step(1, 0, 0, 0);
        mode = 2'd0;
        for (int i = 0; i < 65540; i++) step(0, 1, 1, 0);
        chk("R6", signature, 16'hFFFF);

        // R6 change-count saturation
        step(1, 0, 0, 0);
        mode = 2'd1;
        for (int i = 0; i < 65540; i++) step(0, 1, i[0], 0);
        chk("R6", signature, 16'hFFFF);
        read_all("R6");

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule